// File: doc/BRIEF.md
# Tagged Reservation Station Array

This block holds the arithmetic operations of an out-of-order floating-point core while they wait for operands and execute. It has five slots. Three take add and subtract operations. Two take multiply and divide operations. Each slot keeps an operation code, two operand slots, a busy flag and a latency countdown. An operand slot holds either a value or the tag of the unit that will produce that value. Integer arithmetic stands in for floating-point arithmetic.

An issue unit outside the block presents an operation together with its operands. Each operand comes as a value or as a producer tag. The array places the operation in the lowest free slot of the matching class. Each slot watches every result broadcast: the one from each of its own slots and the one from the load side. When a broadcast tag matches a waiting operand, the slot latches the value. Once both operands are present, the slot counts down a latency set by its operation. It then forms its result and, in the following cycle, drives that result on its own broadcast lane. That broadcast frees the slot.

Tags are 3 bits wide. Tag 0 means "value present". Tags 1 to 3 name add slots 0 to 2. Tags 4 and 5 name multiply slots 0 and 1, which are array entries 3 and 4. Tags 6 and 7 name the two load units.

Top module: `rs_array`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `wb_valid_o` are all zero, and `iss_ok_o` is low while `iss_valid_i` is low.
- R2: An issue with op 0 (add) or op 1 (subtract) goes to the lowest-numbered free entry among entries 0 to 2. An issue with op 2 (multiply) or op 3 (divide) goes to the lowest free entry among entries 3 and 4. `iss_ok_o` is high in the issue cycle, and the entry's `busy_o` bit is set from the next cycle.
- R3: An issue whose class has no free entry is ignored: `iss_ok_o` stays low and `busy_o` does not change.
- R4: If both operands are present when an issue is accepted in cycle t, `done_o` for that entry pulses in cycle t+L and `wb_valid_o` rises in cycle t+L+1. L is 2 for add and subtract, 10 for multiply and 40 for divide.
- R5: The broadcast result is a+b or a−b modulo 2^32, the low 32 bits of a·b, or the unsigned quotient a/b. Division by zero gives all ones.
- R6: A waiting operand whose tag matches an active broadcast (an internal entry, or the load bus with tag 6 or 7) latches that value. The countdown starts in the following cycle, so a capture in cycle b gives `done_o` in cycle b+L and a broadcast in cycle b+L+1.
- R7: If an issued operand's tag matches a broadcast active in the issue cycle, the value is taken at issue and the operand counts as present.
- R8: An entry that broadcasts in cycle w cannot take an issue in cycle w. Its `busy_o` bit is low in cycle w+1, and it can be allocated from then on.
- R9: All entries that are ready broadcast in the same cycle, each on its own lane. A consumer waiting on any one of them picks up the right value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| iss_valid_i | input | 1 | Issue request |
| iss_op_i | input | 2 | Operation: 0 add, 1 sub, 2 mul, 3 div |
| iss_val_a_i | input | 32 | First operand value (used when its tag is 0) |
| iss_tag_a_i | input | 3 | First operand producer tag, 0 = present |
| iss_val_b_i | input | 32 | Second operand value |
| iss_tag_b_i | input | 3 | Second operand producer tag |
| ext_valid_i | input | 1 | Load-side broadcast valid |
| ext_tag_i | input | 3 | Load-side broadcast tag (6 or 7) |
| ext_value_i | input | 32 | Load-side broadcast value |
| iss_ok_o | output | 1 | Issue accepted this cycle |
| busy_o | output | 5 | Per-entry busy flag |
| done_o | output | 5 | Per-entry completion pulse |
| wb_valid_o | output | 5 | Per-entry broadcast valid, the tag being entry index + 1 |
| wb_value_o | output | 5x32 | Per-entry broadcast value |

## Verification
The assertions take three things for granted about the inputs. The load-side bus only carries tags 6 or 7. Issued producer tags only name units that will broadcast later or are broadcasting now. No two sources drive the same tag at once. The stimulus stays within these limits. It draws load tags only from 6 and 7. Random operations are issued with present operands, one at a time. Dependent tags come only from the directed chain, bypass and capture cases, each aimed at a producer that is known to be outstanding.

// File: rtl/rsa_pkg.sv
package rsa_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_DIV = 2'd3
    } rs_op_e;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rsa_bcast_match.sv
module rsa_bcast_match #(
    parameter int DW = 32,
    parameter int TW = 3,
    parameter int NB = 6
) (
    input  logic [TW-1:0]          tag_i,
    input  logic [NB-1:0]          bus_valid_i,
    input  logic [NB-1:0][TW-1:0]  bus_tag_i,
    input  logic [NB-1:0][DW-1:0]  bus_val_i,
    output logic                   hit_o,
    output logic [DW-1:0]          val_o
);
    always_comb begin
        hit_o = 1'b0;
        val_o = '0;
        for (int i = 0; i < NB; i++) begin
            if (bus_valid_i[i] && (tag_i != '0) && (bus_tag_i[i] == tag_i)) begin
                hit_o = 1'b1;
                val_o = val_o | bus_val_i[i];
            end
        end
    end
endmodule

// File: rtl/rsa_alloc.sv
module rsa_alloc #(
    parameter int N = 3
) (
    input  logic         req_i,
    input  logic [N-1:0] busy_i,
    output logic [N-1:0] grant_o,
    output logic         any_free_o
);
    always_comb begin
        grant_o    = '0;
        any_free_o = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!busy_i[i] && !any_free_o) begin
                any_free_o = 1'b1;
                grant_o[i] = req_i;
            end
        end
    end
endmodule

// File: rtl/rsa_entry.sv
module rsa_entry
    import rsa_pkg::*;
#(
    parameter int DW      = 32,
    parameter int TW      = 3,
    parameter int NB      = 6,
    parameter int CW      = 6,
    parameter int LAT_ADD = 2,
    parameter int LAT_MUL = 10,
    parameter int LAT_DIV = 40
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   ld_i,
    input  rs_op_e                 ld_op_i,
    input  logic [TW-1:0]          ld_ta_i,
    input  logic [DW-1:0]          ld_va_i,
    input  logic [TW-1:0]          ld_tb_i,
    input  logic [DW-1:0]          ld_vb_i,
    input  logic [NB-1:0]          bus_valid_i,
    input  logic [NB-1:0][TW-1:0]  bus_tag_i,
    input  logic [NB-1:0][DW-1:0]  bus_val_i,
    output logic                   busy_o,
    output logic                   done_o,
    output logic                   wb_valid_o,
    output logic [DW-1:0]          wb_value_o
);
    typedef struct packed {
        logic [TW-1:0] tag;
        logic [DW-1:0] val;
    } slot_t;

    logic          busy_q;
    rs_op_e        op_q;
    slot_t         sa_q, sb_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] res_q;
    logic [DW-1:0] calc;
    logic          hit_a, hit_b;
    logic [DW-1:0] val_a, val_b;
    logic          waiting, counting, wb;

    function automatic logic [CW-1:0] op_lat(input rs_op_e op);
        case (op)
            OP_MUL:  return CW'(LAT_MUL);
            OP_DIV:  return CW'(LAT_DIV);
            default: return CW'(LAT_ADD);
        endcase
    endfunction

    rsa_bcast_match #(.DW(DW), .TW(TW), .NB(NB)) u_match_a (
        .tag_i(sa_q.tag), .bus_valid_i(bus_valid_i), .bus_tag_i(bus_tag_i),
        .bus_val_i(bus_val_i), .hit_o(hit_a), .val_o(val_a));

    rsa_bcast_match #(.DW(DW), .TW(TW), .NB(NB)) u_match_b (
        .tag_i(sb_q.tag), .bus_valid_i(bus_valid_i), .bus_tag_i(bus_tag_i),
        .bus_val_i(bus_val_i), .hit_o(hit_b), .val_o(val_b));

    assign waiting  = (sa_q.tag != '0) || (sb_q.tag != '0);
    assign wb       = busy_q && (cnt_q == '0);
    assign counting = busy_q && !waiting && !wb;

    always_comb begin
        case (op_q)
            OP_ADD:  calc = sa_q.val + sb_q.val;
            OP_SUB:  calc = sa_q.val - sb_q.val;
            OP_MUL:  calc = sa_q.val * sb_q.val;
            default: calc = (sb_q.val == '0) ? '1 : (sa_q.val / sb_q.val);
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            busy_q <= 1'b0;
            op_q   <= OP_ADD;
            sa_q   <= '0;
            sb_q   <= '0;
            cnt_q  <= '0;
            res_q  <= '0;
        end else if (ld_i) begin
            busy_q <= 1'b1;
            op_q   <= ld_op_i;
            sa_q   <= '{tag: ld_ta_i, val: ld_va_i};
            sb_q   <= '{tag: ld_tb_i, val: ld_vb_i};
            cnt_q  <= op_lat(ld_op_i);
        end else if (wb) begin
            busy_q <= 1'b0;
            sa_q   <= '0;
            sb_q   <= '0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (hit_a) sa_q <= '{tag: '0, val: val_a};
            if (hit_b) sb_q <= '{tag: '0, val: val_b};
            if (counting) begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) res_q <= calc;
            end
        end
    end

    assign busy_o     = busy_q;
    assign done_o     = counting && (cnt_q == CW'(1));
    assign wb_valid_o = wb;
    assign wb_value_o = res_q;

    // An allocation must only target an idle entry
    assert_issue_free_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        ld_i |-> !busy_q);

    // Broadcasting frees the entry for the next cycle
    assert_release_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        wb_valid_o |=> !busy_o);

    // A waiting entry holds its countdown
    assert_hold_wait_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_q && waiting && !wb && !ld_i) |=> (cnt_q == $past(cnt_q)));

    // Completion is followed by the broadcast
    assert_done_then_wb_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> wb_valid_o);
endmodule

// File: rtl/rs_array.sv
module rs_array
    import rsa_pkg::*;
#(
    parameter int DW       = 32,
    parameter int NUM_ADD  = 3,
    parameter int NUM_MUL  = 2,
    parameter int NUM_LOAD = 2,
    parameter int LAT_ADD  = 2,
    parameter int LAT_MUL  = 10,
    parameter int LAT_DIV  = 40,
    localparam int NE      = NUM_ADD + NUM_MUL,
    localparam int NB      = NE + 1,
    localparam int TW      = $clog2(NE + NUM_LOAD + 1),
    localparam int CW      = $clog2(max3(LAT_ADD, LAT_MUL, LAT_DIV) + 1)
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  iss_valid_i,
    input  logic [1:0]            iss_op_i,
    input  logic [DW-1:0]         iss_val_a_i,
    input  logic [TW-1:0]         iss_tag_a_i,
    input  logic [DW-1:0]         iss_val_b_i,
    input  logic [TW-1:0]         iss_tag_b_i,
    input  logic                  ext_valid_i,
    input  logic [TW-1:0]         ext_tag_i,
    input  logic [DW-1:0]         ext_value_i,
    output logic                  iss_ok_o,
    output logic [NE-1:0]         busy_o,
    output logic [NE-1:0]         done_o,
    output logic [NE-1:0]         wb_valid_o,
    output logic [NE-1:0][DW-1:0] wb_value_o
);
    logic [NB-1:0]          bus_valid;
    logic [NB-1:0][TW-1:0]  bus_tag;
    logic [NB-1:0][DW-1:0]  bus_val;
    logic [NUM_ADD-1:0]     grant_a;
    logic [NUM_MUL-1:0]     grant_m;
    logic [NE-1:0]          ld_vec;
    logic                   free_a, free_m, is_long;
    logic                   byp_hit_a, byp_hit_b;
    logic [DW-1:0]          byp_val_a, byp_val_b;
    logic [TW-1:0]          ld_ta, ld_tb;
    logic [DW-1:0]          ld_va, ld_vb;

    generate
        for (genvar i = 0; i < NE; i++) begin : g_lane
            assign bus_valid[i] = wb_valid_o[i];
            assign bus_tag[i]   = TW'(i + 1);
            assign bus_val[i]   = wb_value_o[i];
        end
    endgenerate
    assign bus_valid[NE] = ext_valid_i;
    assign bus_tag[NE]   = ext_tag_i;
    assign bus_val[NE]   = ext_value_i;

    assign is_long = iss_op_i[1];

    rsa_alloc #(.N(NUM_ADD)) u_alloc_add (
        .req_i(iss_valid_i && !is_long), .busy_i(busy_o[NUM_ADD-1:0]),
        .grant_o(grant_a), .any_free_o(free_a));

    rsa_alloc #(.N(NUM_MUL)) u_alloc_mul (
        .req_i(iss_valid_i && is_long), .busy_i(busy_o[NE-1:NUM_ADD]),
        .grant_o(grant_m), .any_free_o(free_m));

    assign ld_vec   = {grant_m, grant_a};
    assign iss_ok_o = iss_valid_i && (is_long ? free_m : free_a);

    rsa_bcast_match #(.DW(DW), .TW(TW), .NB(NB)) u_byp_a (
        .tag_i(iss_tag_a_i), .bus_valid_i(bus_valid), .bus_tag_i(bus_tag),
        .bus_val_i(bus_val), .hit_o(byp_hit_a), .val_o(byp_val_a));

    rsa_bcast_match #(.DW(DW), .TW(TW), .NB(NB)) u_byp_b (
        .tag_i(iss_tag_b_i), .bus_valid_i(bus_valid), .bus_tag_i(bus_tag),
        .bus_val_i(bus_val), .hit_o(byp_hit_b), .val_o(byp_val_b));

    assign ld_ta = byp_hit_a ? '0 : iss_tag_a_i;
    assign ld_va = byp_hit_a ? byp_val_a : iss_val_a_i;
    assign ld_tb = byp_hit_b ? '0 : iss_tag_b_i;
    assign ld_vb = byp_hit_b ? byp_val_b : iss_val_b_i;

    generate
        for (genvar i = 0; i < NE; i++) begin : g_entry
            rsa_entry #(
                .DW(DW), .TW(TW), .NB(NB), .CW(CW),
                .LAT_ADD(LAT_ADD), .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)
            ) u_entry (
                .clk_i(clk_i), .rst_i(rst_i), .ld_i(ld_vec[i]),
                .ld_op_i(rs_op_e'(iss_op_i)),
                .ld_ta_i(ld_ta), .ld_va_i(ld_va), .ld_tb_i(ld_tb), .ld_vb_i(ld_vb),
                .bus_valid_i(bus_valid), .bus_tag_i(bus_tag), .bus_val_i(bus_val),
                .busy_o(busy_o[i]), .done_o(done_o[i]),
                .wb_valid_o(wb_valid_o[i]), .wb_value_o(wb_value_o[i]));
        end
    endgenerate

    // At most one entry of a class is chosen per issue
    assert_grant_onehot_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(ld_vec));

    // Load-side broadcasts only carry load tags
    assert_ext_tag_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        ext_valid_i |-> (ext_tag_i > TW'(NE)));

    // A rejected issue never loads an entry
    assert_reject_full_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        !iss_ok_o |-> (ld_vec == '0));
endmodule

// File: tb/rs_array_tb_top.sv
`timescale 1ns/1ps
module rs_array_tb_top;
    logic             clk = 1'b0;
    logic             rst;
    logic             iss_valid;
    logic [1:0]       iss_op;
    logic [31:0]      iss_va, iss_vb;
    logic [2:0]       iss_ta, iss_tb;
    logic             ext_valid;
    logic [2:0]       ext_tag;
    logic [31:0]      ext_value;
    logic             iss_ok;
    logic [4:0]       busy, done, wbv;
    logic [4:0][31:0] wbval;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    rs_array dut_i (
        .clk_i(clk), .rst_i(rst), .iss_valid_i(iss_valid), .iss_op_i(iss_op),
        .iss_val_a_i(iss_va), .iss_tag_a_i(iss_ta), .iss_val_b_i(iss_vb),
        .iss_tag_b_i(iss_tb), .ext_valid_i(ext_valid), .ext_tag_i(ext_tag),
        .ext_value_i(ext_value), .iss_ok_o(iss_ok), .busy_o(busy), .done_o(done),
        .wb_valid_o(wbv), .wb_value_o(wbval));

    function automatic logic [31:0] exp_res(input logic [1:0] op, input logic [31:0] a,
                                            input logic [31:0] b);
        case (op)
            2'd0:    return a + b;
            2'd1:    return a - b;
            2'd2:    return a * b;
            default: return (b == 0) ? 32'hFFFF_FFFF : a / b;
        endcase
    endfunction

    function automatic int lat_of(input logic [1:0] op);
        return (op == 2'd2) ? 10 : (op == 2'd3) ? 40 : 2;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        iss_valid = 1'b0; iss_op = 2'd0; iss_va = '0; iss_vb = '0;
        iss_ta = '0; iss_tb = '0; ext_valid = 1'b0; ext_tag = '0; ext_value = '0;
    endtask

    task automatic do_reset();
        idle();
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
    endtask

    task automatic put(input logic [1:0] op, input logic [31:0] va, input logic [2:0] ta,
                       input logic [31:0] vb, input logic [2:0] tb);
        iss_valid = 1'b1; iss_op = op; iss_va = va; iss_ta = ta; iss_vb = vb; iss_tb = tb;
        #1;
    endtask

    task automatic ext(input logic [2:0] t, input logic [31:0] v);
        ext_valid = 1'b1; ext_tag = t; ext_value = v;
        #1;
    endtask

    initial begin
        #400000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        do_reset();
        #1;
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 wb", wbv, 0);
        chk("R1 iss_ok", iss_ok, 0);

        // Random independent ops: R2 R4 R5 R8
        for (int k = 0; k < 24; k++) begin
            logic [1:0]  op;
            logic [31:0] a, b;
            int          e, l;
            op = 2'($urandom % 4);
            a  = $urandom;
            b  = $urandom;
            if (op == 2'd3) b = ($urandom % 4 == 0) ? 32'd0 : ($urandom % 5000);
            e = (op >= 2) ? 3 : 0;
            l = lat_of(op);
            put(op, a, 3'd0, b, 3'd0);
            chk("R2 accept", iss_ok, 1);
            step(); idle();
            chk("R2 busy set", busy[e], 1);
            repeat (l - 1) step();
            chk("R4 done pulse", {done[e], wbv[e]}, 2'b10);
            step();
            chk("R4 broadcast", wbv[e], 1);
            chk("R5 result", wbval[e], exp_res(op, a, b));
            step();
            chk("R8 freed", busy[e], 0);
        end

        // Directed divide by zero (R5)
        put(2'd3, 32'd5, 3'd0, 32'd0, 3'd0);
        step(); idle();
        repeat (40) step();
        chk("R5 div0 wb", wbv[3], 1);
        chk("R5 div0 value", wbval[3], 32'hFFFF_FFFF);

        // Fill adders waiting on load tag 6 (R2, R3)
        do_reset();
        for (int j = 0; j < 3; j++) begin
            put(2'd0, 32'd0, 3'd6, 32'(j + 1), 3'd0);
            chk("R2 fill ok", iss_ok, 1);
            step(); idle();
        end
        chk("R2 fill busy", busy, 5'b00111);
        put(2'd1, 32'd1, 3'd0, 32'd1, 3'd0);
        chk("R3 reject", iss_ok, 0);
        step(); idle();
        chk("R3 busy unchanged", busy, 5'b00111);
        put(2'd2, 32'd0, 3'd7, 32'd9, 3'd0);
        chk("R2 mul ok", iss_ok, 1);
        step(); idle();
        chk("R2 mul busy", busy, 5'b01111);
        repeat (3) step();
        chk("R6 no count while waiting", done, 0);

        // Load broadcast tag 6 wakes all three adders (R6, R9)
        ext(3'd6, 32'd10);
        step(); idle();
        step();
        chk("R6 done after capture", done[2:0], 3'b111);
        step();
        chk("R9 simultaneous wb", wbv[2:0], 3'b111);
        chk("R9 value 0", wbval[0], 32'd11);
        chk("R9 value 1", wbval[1], 32'd12);
        chk("R9 value 2", wbval[2], 32'd13);
        put(2'd0, 32'd1, 3'd0, 32'd1, 3'd0);
        chk("R8 no issue in wb cycle", iss_ok, 0);
        step(); idle();
        chk("R8 released", busy[2:0], 3'b000);
        put(2'd0, 32'd1, 3'd0, 32'd1, 3'd0);
        chk("R8 reuse", iss_ok, 1);
        step(); idle();
        ext(3'd7, 32'd4);
        step(); idle();
        repeat (9) step();
        chk("R6 mul done", done[3], 1);
        step();
        chk("R6 mul wb", wbv[3], 1);
        chk("R6 mul value", wbval[3], 32'd36);

        // Producer-consumer chain through the internal bus (R6)
        do_reset();
        put(2'd2, 32'd6, 3'd0, 32'd7, 3'd0);
        step(); idle();
        put(2'd0, 32'd0, 3'd4, 32'd5, 3'd0);
        chk("R2 consumer ok", iss_ok, 1);
        step(); idle();
        repeat (9) step();
        chk("R6 producer wb", wbv[3], 1);
        chk("R6 producer value", wbval[3], 32'd42);
        step();
        chk("R6 no count in capture+1 early", done[0], 0);
        step();
        chk("R6 consumer done", done[0], 1);
        step();
        chk("R6 consumer wb", wbv[0], 1);
        chk("R6 consumer value", wbval[0], 32'd47);

        // Issue-time bypass (R7)
        do_reset();
        put(2'd1, 32'd20, 3'd0, 32'd3, 3'd0);
        step(); idle();
        step(); step();
        chk("R7 producer wb", wbv[0], 1);
        put(2'd0, 32'd0, 3'd1, 32'd100, 3'd0);
        chk("R7 bypass issue ok", iss_ok, 1);
        step(); idle();
        step();
        chk("R7 bypass done", done[1], 1);
        step();
        chk("R7 bypass wb", wbv[1], 1);
        chk("R7 bypass value", wbval[1], 32'd117);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule